// File: doc/BRIEF.md
# Potentiometer Charge-Time Counters with Shared Pin Port

This block measures the resistance of four analog controller inputs by timing how long each pin's capacitor takes to charge. The four pins form two pairs, one pair per controller port, and each pair has a vertical and a horizontal axis. An external threshold comparator gives one digital level per pin. A start command first discharges the capacitors by driving the pins low for one video line. The four counters then restart from zero. Each counter advances once per horizontal line strobe until its pin level rises, which stops that counter. If the pin never rises, the counter saturates at full scale. Because counting follows the line rate, a full-scale reading takes about one frame. A faster line timing makes the counters run proportionally faster.

The same four pins also serve as a small bidirectional port. The control word gives every pin an output-enable bit and a data bit. A pin with its enable set drives its data bit, and its counter ignores the pin level. The live pin levels are read back through a two-flop synchronizer. That synchronized level is also the one the stop logic uses.

Top module: `pot_timer`

## Requirements
- R1: After reset all counters read 0, `pin_oe` and `pin_out` are 0, and no discharge is in progress.
- R2: A control write loads the pin controls. Pin index 3 (right vertical) takes its enable from bit 15 and its data from bit 14. Pin 2 (right horizontal) uses bits 13/12, pin 1 (left vertical) uses bits 11/10, and pin 0 (left horizontal) uses bits 9/8. Outside a discharge, `pin_oe` equals the enables and `pin_out` equals data AND enable.
- R3: A control write with bit 0 set clears all four counters to 0 in the following cycle. It also starts a discharge. During the discharge every pin is output-enabled, and pins without their own enable drive 0. The discharge lasts until the next line strobe, and that strobe does not count.
- R4: After the discharge, each running counter increments by exactly one on every line strobe. Counters change on no other cycle except a start.
- R5: At a line strobe, a counter whose synchronized pin level is high and whose pin enable is clear stops, and it keeps its value until the next start. The other counters continue.
- R6: A counter that reaches 255 holds 255 for the rest of the measurement.
- R7: A pin with its output enable set ignores its pin level for stopping, so its counter keeps counting.
- R8: `pin_lvl` shows `pin_in` delayed by two clock cycles.
- R9: `left_cnt` holds the left vertical counter (pin 1) in bits 15-8 and the left horizontal counter (pin 0) in bits 7-0. `right_cnt` holds pin 3 in bits 15-8 and pin 2 in bits 7-0.
- R10: A control write with bit 0 clear leaves all counter values and their running state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle pulse per horizontal video line |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word (pin enables/data in 15-8, start in 0) |
| pin_in | input | 4 | Comparator levels of the four pins |
| pin_oe | output | 4 | Pin output enables |
| pin_out | output | 4 | Pin output data |
| pin_lvl | output | 4 | Synchronized pin levels |
| left_cnt | output | 16 | Left pair counters {vertical, horizontal} |
| right_cnt | output | 16 | Right pair counters {vertical, horizontal} |

## Verification
The hardest state to reach is a measurement where counters finish at very different lines. One counter stops at line 0, another stops after a few lines, and a third runs into saturation, all in the same run. The bench walks a table of per-pin stop lines and raises each comparator input just before the chosen strobe. It runs more than 255 lines, so zero, mid-range and saturated results all appear together. Directed runs then combine an output-enabled pin that reads high with a non-enabled pin that reads high. This separates "ignore the stop" from "stop".

// File: rtl/pot_timer.sv
module pot_timer #(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_stb,
  input  logic            wr_en,
  input  logic [15:0]     wr_data,
  input  logic [3:0]      pin_in,
  output logic [3:0]      pin_oe,
  output logic [3:0]      pin_out,
  output logic [3:0]      pin_lvl,
  output logic [2*CW-1:0] left_cnt,
  output logic [2*CW-1:0] right_cnt
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [3:0] oe_q, dat_q, run_q, s1_q, s2_q;
  logic       dump_q;
  logic [CW-1:0] cnt_q [4];
  logic start;

  assign start = wr_en & wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q   <= '0;
      dat_q  <= '0;
      run_q  <= '0;
      dump_q <= 1'b0;
      for (int i = 0; i < 4; i++) cnt_q[i] <= '0;
    end else begin
      if (wr_en)
        for (int i = 0; i < 4; i++) begin
          oe_q[i]  <= wr_data[9+2*i];
          dat_q[i] <= wr_data[8+2*i];
        end
      if (start) begin
        dump_q <= 1'b1;
        run_q  <= '0;
        for (int i = 0; i < 4; i++) cnt_q[i] <= '0;
      end else if (line_stb) begin
        if (dump_q) begin
          dump_q <= 1'b0;
          run_q  <= '1;
        end else begin
          for (int i = 0; i < 4; i++)
            if (run_q[i]) begin
              if (s2_q[i] && !oe_q[i]) run_q[i] <= 1'b0;
              else if (cnt_q[i] != CMAX) cnt_q[i] <= cnt_q[i] + 1'b1;
            end
        end
      end
    end
  end

  assign pin_oe    = oe_q | {4{dump_q}};
  assign pin_out   = dat_q & oe_q;
  assign pin_lvl   = s2_q;
  assign left_cnt  = {cnt_q[1], cnt_q[0]};
  assign right_cnt = {cnt_q[3], cnt_q[2]};
endmodule

// File: rtl/pot_timer_chk.sv
module pot_timer_chk #(
  parameter int CW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            line_stb,
  input logic            wr_en,
  input logic [15:0]     wr_data,
  input logic [3:0]      pin_oe,
  input logic [3:0]      pin_lvl,
  input logic [3:0]      oe_q,
  input logic            dump_q,
  input logic [2*CW-1:0] left_cnt,
  input logic [2*CW-1:0] right_cnt
);
  logic st;
  assign st = wr_en & wr_data[0];

  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st |=> (left_cnt == '0 && right_cnt == '0));

  p_discharge_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st |=> (pin_oe == 4'hF));

  p_only_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_stb && !st) |=> ($stable(left_cnt) && $stable(right_cnt)));

  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !st |=> (left_cnt[CW-1:0] == $past(left_cnt[CW-1:0]) ||
             left_cnt[CW-1:0] == $past(left_cnt[CW-1:0]) + 1'b1));

  p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !st && !dump_q && pin_lvl[2] && !oe_q[2]) |=> $stable(right_cnt[CW-1:0]));

  p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (right_cnt[2*CW-1:CW] == '1 && !st) |=> (right_cnt[2*CW-1:CW] == '1));
endmodule

bind pot_timer pot_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .wr_en(wr_en), .wr_data(wr_data),
  .pin_oe(pin_oe), .pin_lvl(pin_lvl), .oe_q(oe_q), .dump_q(dump_q),
  .left_cnt(left_cnt), .right_cnt(right_cnt));

// File: tb/pot_timer_bench.sv
module pot_timer_bench;
  logic clk = 0, rst_n = 0, line_stb = 0, wr_en = 0;
  logic [15:0] wr_data = '0;
  logic [3:0] pin_in = '0;
  logic [3:0] pin_oe, pin_out, pin_lvl;
  logic [15:0] left_cnt, right_cnt;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pot_timer u_pot_timer (.*);

  // {stop line pin3, pin2, pin1, pin0 (9 bits each), expected counts pin3..pin0}
  localparam int NV = 4;
  localparam logic [67:0] VEC [NV] = '{
    {9'd5,   9'd0,   9'd17, 9'd200, 8'd5,   8'd0,   8'd17, 8'd200},
    {9'd255, 9'd300, 9'd1,  9'd2,   8'd255, 8'd255, 8'd1,  8'd2},
    {9'd0,   9'd0,   9'd0,  9'd0,   8'd0,   8'd0,   8'd0,  8'd0},
    {9'd40,  9'd41,  9'd42, 9'd43,  8'd40,  8'd41,  8'd42, 8'd43}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic strobe();
    repeat (3) @(negedge clk);
    line_stb = 1;
    @(negedge clk); line_stb = 0;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 counts", {left_cnt, right_cnt}, 0);
    chk("R1 pins", {pin_oe, pin_out}, 0);

    for (int v = 0; v < NV; v++) begin
      pin_in = '0;
      wr(16'h0001);
      chk("R3 clear", {left_cnt, right_cnt}, 0);
      chk("R3 discharge", {pin_oe, pin_out}, {4'hF, 4'h0});
      strobe();
      chk("R3 end", {pin_oe, left_cnt, right_cnt}, 0);
      for (int k = 0; k < 260; k++) begin
        for (int i = 0; i < 4; i++)
          pin_in[i] = (k >= int'(VEC[v][32+9*i +: 9]));
        strobe();
      end
      chk("R5 R6 R9 left", left_cnt, {VEC[v][15:8], VEC[v][7:0]});
      chk("R5 R6 R9 right", right_cnt, {VEC[v][31:24], VEC[v][23:16]});
    end

    // R2 pin control mapping
    wr(16'hC000); chk("R2 right vert", {pin_oe, pin_out}, {4'b1000, 4'b1000});
    wr(16'h2000); chk("R2 right horiz", {pin_oe, pin_out}, {4'b0100, 4'b0000});
    wr(16'h0C00); chk("R2 left vert", {pin_oe, pin_out}, {4'b0010, 4'b0010});
    wr(16'h0100); chk("R2 left horiz data no oe", {pin_oe, pin_out}, 8'h00);

    // R7 enabled pin ignores stop; non-enabled high pin stops at 0
    pin_in = 4'b0011;
    wr(16'h0301);
    chk("R3 with oe", {pin_oe, pin_out}, {4'hF, 4'b0001});
    strobe();
    for (int k = 0; k < 10; k++) strobe();
    chk("R7 left", left_cnt, {8'd0, 8'd10});
    chk("R4 right", right_cnt, {8'd10, 8'd10});
    chk("R2 during count", {pin_oe, pin_out}, {4'b0001, 4'b0001});

    // R10 plain control write mid-count
    pin_in = '0;
    wr(16'h0001); strobe();
    for (int k = 0; k < 5; k++) strobe();
    wr(16'h0000);
    chk("R10 unchanged", {left_cnt, right_cnt}, {4{8'd5}});
    for (int k = 0; k < 3; k++) strobe();
    chk("R10 continues", {left_cnt, right_cnt}, {4{8'd8}});

    // R4 no change without strobe
    repeat (6) @(negedge clk);
    chk("R4 idle", {left_cnt, right_cnt}, {4{8'd8}});

    // R8 two-cycle synchronizer
    pin_in = 4'b1010;
    repeat (3) @(negedge clk);
    chk("R8 settled", pin_lvl, 4'b1010);
    pin_in = 4'b0101;
    @(negedge clk); chk("R8 one cycle", pin_lvl, 4'b1010);
    @(negedge clk); chk("R8 two cycles", pin_lvl, 4'b0101);

    // R1 reset mid-count
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1 after reset", {left_cnt, right_cnt, pin_oe, pin_out}, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule